// File: doc/BRIEF.md
# Mode-Banked Processor Register File

This block holds the 32-bit general registers of a core that runs in several privilege modes. Sixteen live registers (numbers 0 to 15) and one live saved-status word are always visible to the datapath through a combinational read port and a one-cycle write port. Behind them sit backing stores: stack-pointer (R13), link (R14) and saved-status copies for every mode group, plus two sets of R8–R12, one for fast-interrupt mode and one shared by every other mode.

A mode-change request swaps the banked registers in a single clock edge. The live values go to the outgoing mode's stores and the incoming mode's copies are loaded. The link register uses its own group mapping. Hypervisor mode keeps a private stack pointer and saved status, but its link register is the same storage as the user/system one. A second port reads or writes the copy that belongs to any named mode. This port serves instructions that move banked registers across modes.

Top module: `modebank_regfile`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears every live and banked register and the live saved status to zero, sets `cur_mode` to supervisor (0x13) and clears `mode_err`.
- R2: `rd_data` shows live register `rd_idx` combinationally. With `wr_en` high, live register `wr_idx` takes `wr_data` at the next edge. `sts_we` writes the live saved status in the same way, and `sts_rdata` shows it.
- R3: Mode encodings are user 0x10, fast-interrupt 0x11, interrupt 0x12, supervisor 0x13, abort 0x17, hypervisor 0x1A, undefined 0x1B and system 0x1F. User and system form one group and every other mode is its own group. A valid request saves the live R13 and saved status into the old group's store and loads them from the new group's store, and `cur_mode` becomes the requested mode.
- R4: R14 is stored per group in the same way, except that hypervisor uses the user/system R14 store.
- R5: Switching from user or system into hypervisor leaves the live R14 unchanged.
- R6: Entering fast-interrupt mode saves live R8–R12 into the shared set and loads the fast-interrupt set. Leaving it does the reverse. Switches that neither enter nor leave fast-interrupt mode do not touch R8–R12.
- R7: On the banked port (`bk_mode`, `bk_reg`), register 13 selects the target group's R13, and register 14 selects the target's R14 through the link mapping of R4. When the target maps to the same store as the current mode, the port reaches the live register. `bk_rdata` is combinational, and a write with `bk_en` and `bk_we` lands at the next edge.
- R8: On the banked port, registers 8 to 12 select the fast-interrupt set when the target is fast-interrupt mode and the shared set otherwise. The live register is used when that set is the one currently loaded.
- R9: On the banked port, registers 0 to 7 and 15 are not banked and reach the live register.
- R10: A valid mode-change request in a cycle blocks the live, status and banked writes of that cycle.
- R11: A request or banked access with an encoding not listed in R3 changes no register or mode. `mode_err` is high for exactly the following cycle, and `bk_rdata` reads zero for such a target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Live register write enable |
| wr_idx | input | 4 | Live register write number |
| wr_data | input | 32 | Live register write data |
| rd_idx | input | 4 | Live register read number |
| rd_data | output | 32 | Live register read data |
| sts_we | input | 1 | Live saved-status write enable |
| sts_wdata | input | 32 | Live saved-status write data |
| sts_rdata | output | 32 | Live saved-status value |
| mode_req_valid | input | 1 | Mode-change request |
| mode_req | input | 5 | Requested mode encoding |
| cur_mode | output | 5 | Current mode encoding |
| mode_err | output | 1 | Invalid encoding seen in previous cycle |
| bk_en | input | 1 | Banked port access enable |
| bk_we | input | 1 | Banked port write (with bk_en) |
| bk_mode | input | 5 | Banked port target mode |
| bk_reg | input | 4 | Banked port register number |
| bk_wdata | input | 32 | Banked port write data |
| bk_rdata | output | 32 | Banked port read data |

## Verification
The switching path is driven through a chain of transitions. Supervisor to user and back shows that per-group stores are kept apart. User to hypervisor to system shows that R13 is split while R14 is shared, which is where a single shared mapping and a fully separate mapping give different answers. Entering and leaving fast-interrupt mode with distinct R8 values shows which high set is live. Banked-port reads are aimed at the current mode, at a mode that shares its store with the current one and at fully foreign modes, so that a wrong live-versus-store choice shows up. Directed cases cover reset, a switch that collides with all three write paths, and invalid encodings on both ports.

// File: rtl/modebank_pkg.sv
package modebank_pkg;

    localparam int DW      = 32;
    localparam int NGRP    = 7;
    localparam int GW      = $clog2(NGRP);
    localparam int NHI     = 5;
    localparam int HI_BASE = 8;
    localparam int HW      = $clog2(NHI);
    localparam int SP_NUM  = 13;
    localparam int LR_NUM  = 14;

    typedef enum logic [4:0] {
        MD_USR = 5'h10,
        MD_FIQ = 5'h11,
        MD_IRQ = 5'h12,
        MD_SVC = 5'h13,
        MD_ABT = 5'h17,
        MD_HYP = 5'h1A,
        MD_UND = 5'h1B,
        MD_SYS = 5'h1F
    } mode_e;

    typedef enum logic [2:0] {
        SEL_LIVE,
        SEL_SP,
        SEL_LR,
        SEL_FIQHI,
        SEL_USRHI
    } sel_e;

    function automatic logic mode_valid(input logic [4:0] m);
        case (m)
            MD_USR, MD_FIQ, MD_IRQ, MD_SVC,
            MD_ABT, MD_HYP, MD_UND, MD_SYS: return 1'b1;
            default:                        return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/modebank_map.sv
module modebank_map
    import modebank_pkg::*;
(
    input  logic [4:0]    mode,
    output logic          ok,
    output logic [GW-1:0] grp,
    output logic [GW-1:0] lr_grp,
    output logic          is_fiq
);
    // group 0 is user/system, shared by the link mapping of hypervisor
    always_comb begin
        ok  = 1'b1;
        grp = '0;
        case (mode)
            MD_USR, MD_SYS: grp = GW'(0);
            MD_FIQ:         grp = GW'(1);
            MD_IRQ:         grp = GW'(2);
            MD_SVC:         grp = GW'(3);
            MD_ABT:         grp = GW'(4);
            MD_HYP:         grp = GW'(5);
            MD_UND:         grp = GW'(6);
            default:        ok  = 1'b0;
        endcase
        lr_grp = (mode == MD_HYP) ? GW'(0) : grp;
        is_fiq = (mode == MD_FIQ);
    end
endmodule

// File: rtl/modebank_bksel.sv
module modebank_bksel
    import modebank_pkg::*;
(
    input  logic [3:0]    reg_num,
    input  logic [GW-1:0] tgt_grp,
    input  logic [GW-1:0] tgt_lr_grp,
    input  logic          tgt_fiq,
    input  logic [GW-1:0] cur_grp,
    input  logic [GW-1:0] cur_lr_grp,
    input  logic          cur_fiq,
    output sel_e          sel,
    output logic [HW-1:0] hi_idx
);
    logic [3:0] hi_off;

    always_comb begin
        hi_off = reg_num - 4'(HI_BASE);
        hi_idx = hi_off[HW-1:0];
        if (reg_num == 4'(SP_NUM)) begin
            sel = (tgt_grp == cur_grp) ? SEL_LIVE : SEL_SP;
        end else if (reg_num == 4'(LR_NUM)) begin
            sel = (tgt_lr_grp == cur_lr_grp) ? SEL_LIVE : SEL_LR;
        end else if (reg_num >= 4'(HI_BASE) && reg_num < 4'(HI_BASE + NHI)) begin
            if (tgt_fiq == cur_fiq) sel = SEL_LIVE;
            else if (tgt_fiq)       sel = SEL_FIQHI;
            else                    sel = SEL_USRHI;
        end else begin
            sel = SEL_LIVE;
        end
    end
endmodule

// File: rtl/modebank_regfile.sv
module modebank_regfile
    import modebank_pkg::*;
#(
    parameter int DATA_W = DW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [3:0]        wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [3:0]        rd_idx,
    output logic [DATA_W-1:0] rd_data,
    input  logic              sts_we,
    input  logic [DATA_W-1:0] sts_wdata,
    output logic [DATA_W-1:0] sts_rdata,
    input  logic              mode_req_valid,
    input  logic [4:0]        mode_req,
    output logic [4:0]        cur_mode,
    output logic              mode_err,
    input  logic              bk_en,
    input  logic              bk_we,
    input  logic [4:0]        bk_mode,
    input  logic [3:0]        bk_reg,
    input  logic [DATA_W-1:0] bk_wdata,
    output logic [DATA_W-1:0] bk_rdata
);
    typedef struct packed {
        logic [15:0][DATA_W-1:0]   live;
        logic [DATA_W-1:0]         sts;
        logic [NGRP-1:0][DATA_W-1:0] sp;
        logic [NGRP-1:0][DATA_W-1:0] lr;
        logic [NGRP-1:0][DATA_W-1:0] ss;
        logic [NHI-1:0][DATA_W-1:0]  fhi;
        logic [NHI-1:0][DATA_W-1:0]  uhi;
        logic [4:0]                mode;
        logic                      err;
    } state_t;

    state_t s_q, s_d;

    logic          cur_ok, req_ok, bk_ok;
    logic [GW-1:0] cur_grp, cur_lgrp, req_grp, req_lgrp, bk_grp, bk_lgrp;
    logic          cur_fiq, req_fiq, bk_fiq;
    sel_e          bk_sel;
    logic [HW-1:0] bk_hi;

    modebank_map u_map_cur (
        .mode(s_q.mode), .ok(cur_ok), .grp(cur_grp), .lr_grp(cur_lgrp), .is_fiq(cur_fiq)
    );
    modebank_map u_map_req (
        .mode(mode_req), .ok(req_ok), .grp(req_grp), .lr_grp(req_lgrp), .is_fiq(req_fiq)
    );
    modebank_map u_map_bk (
        .mode(bk_mode), .ok(bk_ok), .grp(bk_grp), .lr_grp(bk_lgrp), .is_fiq(bk_fiq)
    );

    modebank_bksel u_bksel (
        .reg_num   (bk_reg),
        .tgt_grp   (bk_grp),
        .tgt_lr_grp(bk_lgrp),
        .tgt_fiq   (bk_fiq),
        .cur_grp   (cur_grp),
        .cur_lr_grp(cur_lgrp),
        .cur_fiq   (cur_fiq),
        .sel       (bk_sel),
        .hi_idx    (bk_hi)
    );

    always_comb begin
        s_d     = s_q;
        s_d.err = (mode_req_valid && !req_ok) || (bk_en && !bk_ok);
        if (mode_req_valid) begin
            if (req_ok && cur_ok) begin
                // save outgoing copies first, then load from the updated stores
                s_d.sp[cur_grp]  = s_q.live[SP_NUM];
                s_d.ss[cur_grp]  = s_q.sts;
                s_d.lr[cur_lgrp] = s_q.live[LR_NUM];
                if (cur_fiq != req_fiq) begin
                    for (int k = 0; k < NHI; k++) begin
                        if (cur_fiq) begin
                            s_d.fhi[k]           = s_q.live[HI_BASE + k];
                            s_d.live[HI_BASE + k] = s_q.uhi[k];
                        end else begin
                            s_d.uhi[k]           = s_q.live[HI_BASE + k];
                            s_d.live[HI_BASE + k] = s_q.fhi[k];
                        end
                    end
                end
                s_d.live[SP_NUM] = s_d.sp[req_grp];
                s_d.sts          = s_d.ss[req_grp];
                s_d.live[LR_NUM] = s_d.lr[req_lgrp];
                s_d.mode         = mode_req;
            end
        end else begin
            if (wr_en)  s_d.live[wr_idx] = wr_data;
            if (sts_we) s_d.sts          = sts_wdata;
            if (bk_en && bk_we && bk_ok) begin
                case (bk_sel)
                    SEL_LIVE:  s_d.live[bk_reg] = bk_wdata;
                    SEL_SP:    s_d.sp[bk_grp]   = bk_wdata;
                    SEL_LR:    s_d.lr[bk_lgrp]  = bk_wdata;
                    SEL_FIQHI: s_d.fhi[bk_hi]   = bk_wdata;
                    SEL_USRHI: s_d.uhi[bk_hi]   = bk_wdata;
                    default:   ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q      <= '0;
            s_q.mode <= MD_SVC;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        if (!bk_ok) begin
            bk_rdata = '0;
        end else begin
            case (bk_sel)
                SEL_LIVE:  bk_rdata = s_q.live[bk_reg];
                SEL_SP:    bk_rdata = s_q.sp[bk_grp];
                SEL_LR:    bk_rdata = s_q.lr[bk_lgrp];
                SEL_FIQHI: bk_rdata = s_q.fhi[bk_hi];
                SEL_USRHI: bk_rdata = s_q.uhi[bk_hi];
                default:   bk_rdata = '0;
            endcase
        end
    end

    assign rd_data   = s_q.live[rd_idx];
    assign sts_rdata = s_q.sts;
    assign cur_mode  = s_q.mode;
    assign mode_err  = s_q.err;

endmodule

// File: rtl/modebank_regfile_chk.sv
module modebank_regfile_chk
    import modebank_pkg::*;
#(
    parameter int DATA_W = DW
) (
    input logic              clk,
    input logic              rst,
    input logic              mode_req_valid,
    input logic [4:0]        mode_req,
    input logic [4:0]        cur_mode,
    input logic              mode_err,
    input logic              bk_en,
    input logic [4:0]        bk_mode,
    input logic [DATA_W-1:0] lr_live
);
    logic bad_req, bad_bk;
    assign bad_req = mode_req_valid && !mode_valid(mode_req);
    assign bad_bk  = bk_en && !mode_valid(bk_mode);

    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (cur_mode == MD_SVC && !mode_err)); // R1

    AST_SWITCH_TAKES: assert property (@(posedge clk) disable iff (rst)
        (mode_req_valid && mode_valid(mode_req)) |=> (cur_mode == $past(mode_req))); // R3

    AST_MODE_HELD: assert property (@(posedge clk) disable iff (rst)
        !mode_req_valid |=> $stable(cur_mode)); // R3

    AST_HYP_KEEPS_LR: assert property (@(posedge clk) disable iff (rst)
        (mode_req_valid && mode_req == MD_HYP && (cur_mode == MD_USR || cur_mode == MD_SYS))
        |=> $stable(lr_live)); // R5

    AST_BAD_FLAGGED: assert property (@(posedge clk) disable iff (rst)
        bad_req |=> (mode_err && $stable(cur_mode))); // R11

    AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (rst)
        !(bad_req || bad_bk) |=> !mode_err); // R11

endmodule

bind modebank_regfile modebank_regfile_chk #(.DATA_W(DATA_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .mode_req_valid(mode_req_valid),
    .mode_req      (mode_req),
    .cur_mode      (cur_mode),
    .mode_err      (mode_err),
    .bk_en         (bk_en),
    .bk_mode       (bk_mode),
    .lr_live       (s_q.live[14])
);

// File: tb/modebank_regfile_bench.sv
`timescale 1ns/1ps
module modebank_regfile_bench;

    localparam logic [2:0] OP_WR = 3'd0; // live write idx <= data
    localparam logic [2:0] OP_SW = 3'd1; // mode switch
    localparam logic [2:0] OP_BW = 3'd2; // banked write
    localparam logic [2:0] OP_CL = 3'd3; // check live idx == data
    localparam logic [2:0] OP_CB = 3'd4; // check banked read == data
    localparam logic [2:0] OP_CM = 3'd5; // check cur_mode == mode
    localparam logic [2:0] OP_WS = 3'd6; // status write
    localparam logic [2:0] OP_CS = 3'd7; // check status == data

    typedef struct packed {
        logic [2:0]  op;
        logic [3:0]  req;
        logic [4:0]  mode;
        logic [3:0]  idx;
        logic [31:0] data;
    } vec_t;

    localparam int NV = 43;
    localparam vec_t TBL [NV] = '{
        '{OP_WR, 4'd2,  5'h13, 4'd13, 32'hA000_0001},
        '{OP_WR, 4'd2,  5'h13, 4'd14, 32'hA000_0002},
        '{OP_CL, 4'd2,  5'h13, 4'd13, 32'hA000_0001}, // R2
        '{OP_SW, 4'd3,  5'h10, 4'd0,  32'h0},
        '{OP_CL, 4'd3,  5'h00, 4'd13, 32'h0},          // R3 user stack separate
        '{OP_CM, 4'd3,  5'h10, 4'd0,  32'h0},          // R3
        '{OP_WR, 4'd2,  5'h10, 4'd13, 32'hB000_0001},
        '{OP_WR, 4'd2,  5'h10, 4'd14, 32'hB000_0002},
        '{OP_SW, 4'd5,  5'h1A, 4'd0,  32'h0},
        '{OP_CL, 4'd5,  5'h00, 4'd14, 32'hB000_0002}, // R5 link kept on hyp entry
        '{OP_CL, 4'd3,  5'h00, 4'd13, 32'h0},          // R3 hyp own stack
        '{OP_WR, 4'd2,  5'h1A, 4'd13, 32'hC000_0001},
        '{OP_WR, 4'd2,  5'h1A, 4'd14, 32'hC000_0002},
        '{OP_SW, 4'd4,  5'h1F, 4'd0,  32'h0},
        '{OP_CL, 4'd4,  5'h00, 4'd14, 32'hC000_0002}, // R4 shared link
        '{OP_CL, 4'd3,  5'h00, 4'd13, 32'hB000_0001}, // R3 user/system stack
        '{OP_SW, 4'd3,  5'h13, 4'd0,  32'h0},
        '{OP_CL, 4'd3,  5'h00, 4'd13, 32'hA000_0001}, // R3
        '{OP_CL, 4'd4,  5'h00, 4'd14, 32'hA000_0002}, // R4 supervisor own link
        '{OP_WR, 4'd2,  5'h13, 4'd8,  32'hD000_0008},
        '{OP_SW, 4'd6,  5'h11, 4'd0,  32'h0},
        '{OP_CL, 4'd6,  5'h00, 4'd8,  32'h0},          // R6 fiq set loaded
        '{OP_WR, 4'd2,  5'h11, 4'd8,  32'hE000_0008},
        '{OP_WR, 4'd2,  5'h11, 4'd13, 32'hF000_0001},
        '{OP_CB, 4'd8,  5'h10, 4'd8,  32'hD000_0008}, // R8 shared set from fiq
        '{OP_CB, 4'd8,  5'h11, 4'd8,  32'hE000_0008}, // R8 live
        '{OP_CB, 4'd7,  5'h1A, 4'd14, 32'hC000_0002}, // R7 hyp link via shared store
        '{OP_CB, 4'd7,  5'h1A, 4'd13, 32'hC000_0001}, // R7
        '{OP_CB, 4'd7,  5'h13, 4'd13, 32'hA000_0001}, // R7
        '{OP_CB, 4'd7,  5'h11, 4'd13, 32'hF000_0001}, // R7 live
        '{OP_BW, 4'd7,  5'h12, 4'd13, 32'h0000_0099},
        '{OP_SW, 4'd3,  5'h12, 4'd0,  32'h0},
        '{OP_CL, 4'd7,  5'h00, 4'd13, 32'h0000_0099}, // R7 banked write landed
        '{OP_CL, 4'd6,  5'h00, 4'd8,  32'hD000_0008}, // R6 shared set restored
        '{OP_CB, 4'd8,  5'h11, 4'd8,  32'hE000_0008}, // R8 fiq set from irq
        '{OP_CB, 4'd3,  5'h11, 4'd13, 32'hF000_0001}, // R3 fiq stack saved
        '{OP_BW, 4'd9,  5'h10, 4'd3,  32'h0000_0033},
        '{OP_CL, 4'd9,  5'h00, 4'd3,  32'h0000_0033}, // R9
        '{OP_CB, 4'd9,  5'h1F, 4'd3,  32'h0000_0033}, // R9
        '{OP_WS, 4'd2,  5'h12, 4'd0,  32'h0000_005A},
        '{OP_SW, 4'd3,  5'h13, 4'd0,  32'h0},
        '{OP_CS, 4'd3,  5'h00, 4'd0,  32'h0},          // R3 supervisor status
        '{OP_SW, 4'd3,  5'h12, 4'd0,  32'h0}
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en, sts_we, mode_req_valid, bk_en, bk_we;
    logic [3:0]  wr_idx, rd_idx, bk_reg;
    logic [31:0] wr_data, sts_wdata, bk_wdata;
    logic [31:0] rd_data, sts_rdata, bk_rdata;
    logic [4:0]  mode_req, bk_mode, cur_mode;
    logic        mode_err;

    int n_chk = 0;
    int n_err = 0;

    always #4 clk = ~clk;

    modebank_regfile u_modebank_regfile (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .rd_idx(rd_idx), .rd_data(rd_data),
        .sts_we(sts_we), .sts_wdata(sts_wdata), .sts_rdata(sts_rdata),
        .mode_req_valid(mode_req_valid), .mode_req(mode_req),
        .cur_mode(cur_mode), .mode_err(mode_err),
        .bk_en(bk_en), .bk_we(bk_we), .bk_mode(bk_mode), .bk_reg(bk_reg),
        .bk_wdata(bk_wdata), .bk_rdata(bk_rdata)
    );

    task automatic idle();
        wr_en = 0; wr_idx = 0; wr_data = 0; rd_idx = 0;
        sts_we = 0; sts_wdata = 0;
        mode_req_valid = 0; mode_req = 5'h10;
        bk_en = 0; bk_we = 0; bk_mode = 5'h10; bk_reg = 0; bk_wdata = 0;
    endtask

    task automatic check(input int req, input string what, input logic [31:0] got,
                         input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL R%0d %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        idle();
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;

        // R1: reset state
        #1;
        check(1, "mode after reset", {27'd0, cur_mode}, 32'h13);
        check(1, "err after reset", {31'd0, mode_err}, 32'h0);
        check(1, "status after reset", sts_rdata, 32'h0);
        for (int i = 0; i < 16; i++) begin
            rd_idx = 4'(i);
            #1;
            check(1, "live reg after reset", rd_data, 32'h0);
        end

        // vector table
        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            idle();
            case (TBL[v].op)
                OP_WR: begin wr_en = 1; wr_idx = TBL[v].idx; wr_data = TBL[v].data; end
                OP_WS: begin sts_we = 1; sts_wdata = TBL[v].data; end
                OP_SW: begin mode_req_valid = 1; mode_req = TBL[v].mode; end
                OP_BW: begin
                    bk_en = 1; bk_we = 1; bk_mode = TBL[v].mode;
                    bk_reg = TBL[v].idx; bk_wdata = TBL[v].data;
                end
                OP_CL: begin rd_idx = TBL[v].idx; #2;
                    check(int'(TBL[v].req), "live read", rd_data, TBL[v].data); end
                OP_CB: begin bk_mode = TBL[v].mode; bk_reg = TBL[v].idx; #2;
                    check(int'(TBL[v].req), "banked read", bk_rdata, TBL[v].data); end
                OP_CM: begin #2;
                    check(int'(TBL[v].req), "mode", {27'd0, cur_mode}, {27'd0, TBL[v].mode}); end
                OP_CS: begin #2;
                    check(int'(TBL[v].req), "status", sts_rdata, TBL[v].data); end
                default: ;
            endcase
        end
        @(negedge clk);
        idle();
        #2;
        check(3, "irq status restored", sts_rdata, 32'h0000_005A); // R3

        // R10: switch to user collides with live, status and banked writes
        @(negedge clk);
        mode_req_valid = 1; mode_req = 5'h10;
        wr_en = 1; wr_idx = 4'd13; wr_data = 32'h66;
        sts_we = 1; sts_wdata = 32'h11;
        bk_en = 1; bk_we = 1; bk_mode = 5'h12; bk_reg = 4'd13; bk_wdata = 32'h77;
        @(negedge clk);
        idle();
        rd_idx = 4'd13; bk_mode = 5'h12; bk_reg = 4'd13;
        #2;
        check(10, "mode after collision", {27'd0, cur_mode}, 32'h10);
        check(10, "live r13 not overwritten", rd_data, 32'hB000_0001);
        check(10, "status not overwritten", sts_rdata, 32'h0);
        check(10, "banked irq r13 not overwritten", bk_rdata, 32'h99);

        // R11: invalid mode request
        @(negedge clk);
        idle();
        mode_req_valid = 1; mode_req = 5'h15;
        @(negedge clk);
        idle();
        rd_idx = 4'd13;
        #2;
        check(11, "mode kept on bad request", {27'd0, cur_mode}, 32'h10);
        check(11, "err raised", {31'd0, mode_err}, 32'h1);
        check(11, "live r13 kept", rd_data, 32'hB000_0001);
        @(negedge clk);
        #2;
        check(11, "err one cycle only", {31'd0, mode_err}, 32'h0);

        // R11: invalid banked target
        @(negedge clk);
        idle();
        bk_en = 1; bk_we = 1; bk_mode = 5'h00; bk_reg = 4'd13; bk_wdata = 32'h55;
        #2;
        check(11, "bad target reads zero", bk_rdata, 32'h0);
        @(negedge clk);
        idle();
        rd_idx = 4'd13;
        #2;
        check(11, "err on bad target", {31'd0, mode_err}, 32'h1);
        check(11, "bad banked write ignored", rd_data, 32'hB000_0001);

        finish_run();
    end

endmodule